// File: doc/BRIEF.md
# Destination Address Filter

This block sits beside a receive datapath and decides, while a frame's header is still arriving, whether the frame is addressed to this station. The six destination address bytes are offered one per cycle, first byte first, after a frame-start pulse. The block collects them, runs the Ethernet CRC-32 over them one byte per cycle, and from the six most significant CRC bits picks one bit of a 64-entry multicast hash table. The table index, the programmed station address and three mode controls together produce a single accept or reject verdict.

Control is a three-state machine. `ST_IDLE` is the state after reset; the `idle_to_gather` transition is taken on `frame_start`. In `ST_GATHER` each accepted byte advances the byte count and the CRC; `gather_restart` stays in `ST_GATHER` when another `frame_start` arrives, and `gather_to_hold` is taken when the sixth byte is accepted. In `ST_HOLD` the verdict is presented and frozen; `hold_restart` returns to `ST_GATHER` on the next `frame_start`, otherwise `hold_stay` keeps it.

The CRC starts from all ones, consumes each byte least significant bit first with polynomial 0x04C11DB7, and is not inverted; the table index is CRC bits 31:26.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset `verdict_valid` and `verdict_accept` are both 0.
- R2: A frame whose first address byte has bit 0 set, and which is not all-ones, is accepted exactly when the table bit selected by the index (CRC bits 31:26) is set; index values 0 to 31 select bit index of `hash_low`, values 32 to 63 select bit index-32 of `hash_high`.
- R3: The all-ones address is accepted when `reject_bcast` is 0 and rejected when it is 1, whatever the hash table holds.
- R4: When `promisc` is 1 every frame is accepted, including broadcast with `reject_bcast` set.
- R5: A frame whose first byte has bit 0 clear is accepted when its six bytes equal the station address, held as first byte in `station_hi[15:8]`, second in `station_hi[7:0]`, third in `station_lo[31:24]`, fourth in `station_lo[23:16]`, fifth in `station_lo[15:8]`, sixth in `station_lo[7:0]`.
- R6: A non-matching individual address is rejected, unless `hash_unicast` is 1 and its hash table bit is set, in which case it is accepted.
- R7: `verdict_valid` rises in the cycle after the sixth byte is taken and stays 1, with `verdict_accept` unchanged, until the next `frame_start`; bytes offered after the sixth are ignored.
- R8: `frame_start` restarts address collection and `verdict_valid` is 0 in the cycle after it; a byte offered in the same cycle as `frame_start` is ignored, and idle cycles between bytes are allowed.
- R9: Changes to the table, station address or mode inputs after the verdict is formed do not alter `verdict_accept`.
- R10: `verdict_accept` is 0 whenever `verdict_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse marking a new frame |
| byte_valid | input | 1 | `byte_data` carries an address byte |
| byte_data | input | 8 | Destination address byte, first byte first |
| station_lo | input | 32 | Station address bytes three to six |
| station_hi | input | 16 | Station address bytes one and two |
| hash_low | input | 32 | Hash table entries 0 to 31 |
| hash_high | input | 32 | Hash table entries 32 to 63 |
| reject_bcast | input | 1 | Reject the all-ones address |
| promisc | input | 1 | Accept every frame |
| hash_unicast | input | 1 | Also use the hash table for individual addresses |
| verdict_valid | output | 1 | Verdict is available |
| verdict_accept | output | 1 | Frame is accepted |

## Verification
The embedded properties watch every cycle for the timing of the verdict after the sixth byte, its freezing until a new frame start, its clearing by frame start, the promiscuous and broadcast-reject overrides, and the rule that no accept appears without a valid verdict. Whether the CRC index lands on the right table bit, whether the station address bytes are compared in the right order, and how the unicast hash option combines with an address mismatch can only be shown by the bench's scenarios, which compute the expected verdict from a separate model of the rules and compare it as each verdict appears.

// File: rtl/dafl_pkg.sv
package dafl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_HOLD   = 2'd2
    } dafl_state_e;

    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

    // One byte of the serial Ethernet CRC, data bits taken LSB first.
    function automatic logic [31:0] crc_step(input logic [31:0] c_in,
                                             input logic [7:0]  d_in);
        logic [31:0] r;
        logic        fb;
        r = c_in;
        for (int i = 0; i < 8; i++) begin
            fb = r[31] ^ d_in[i];
            r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
        end
        return r;
    endfunction

endpackage

// File: rtl/dafl_crc.sv
module dafl_crc #(
    parameter int BYTE_W    = 8,
    parameter int HASH_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 take,
    input  logic [BYTE_W-1:0]    din,
    output logic [HASH_BITS-1:0] idx_nxt
);
    import dafl_pkg::*;

    localparam int CRC_W = 32;

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_upd;

    always_comb begin
        crc_upd = crc_step(crc_q, din);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            crc_q <= '1;
        end else if (take) begin
            crc_q <= crc_upd;
        end
    end

    assign idx_nxt = crc_upd[CRC_W-1 -: HASH_BITS];

    // R8: a new frame always starts the CRC from all ones
    assert_crc_seeded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc_q == '1));

endmodule

// File: rtl/dafl_addr_reg.sv
module dafl_addr_reg #(
    parameter int BYTE_W     = 8,
    parameter int ADDR_BYTES = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         take,
    input  logic [BYTE_W-1:0]            din,
    output logic [BYTE_W*ADDR_BYTES-1:0] addr_nxt
);
    localparam int ADDR_W = BYTE_W * ADDR_BYTES;

    logic [ADDR_W-1:0] addr_q;

    // First byte ends up in the most significant position.
    assign addr_nxt = {addr_q[ADDR_W-BYTE_W-1:0], din};

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            addr_q <= '0;
        end else if (take) begin
            addr_q <= addr_nxt;
        end
    end

endmodule

// File: rtl/dafl_rules.sv
module dafl_rules #(
    parameter int BYTE_W     = 8,
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6
) (
    input  logic [BYTE_W*ADDR_BYTES-1:0]    addr,
    input  logic [HASH_BITS-1:0]            idx,
    input  logic [BYTE_W*ADDR_BYTES-1:0]    station,
    input  logic [(1<<HASH_BITS)-1:0]       table_bits,
    input  logic                            reject_bcast,
    input  logic                            promisc,
    input  logic                            hash_unicast,
    output logic                            accept
);
    localparam int ADDR_W   = BYTE_W * ADDR_BYTES;
    localparam int GROUP_B  = ADDR_W - BYTE_W;

    logic group_addr;
    logic all_ones;
    logic own_match;
    logic hash_hit;

    always_comb begin
        group_addr = addr[GROUP_B];
        all_ones   = &addr;
        own_match  = (addr == station);
        hash_hit   = table_bits[idx];

        if (promisc) begin
            accept = 1'b1;
        end else if (all_ones) begin
            accept = !reject_bcast;
        end else if (group_addr) begin
            accept = hash_hit;
        end else begin
            accept = own_match || (hash_unicast && hash_hit);
        end
    end

endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter #(
    parameter int BYTE_W     = 8,
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_start,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    input  logic [31:0] station_lo,
    input  logic [15:0] station_hi,
    input  logic [31:0] hash_low,
    input  logic [31:0] hash_high,
    input  logic        reject_bcast,
    input  logic        promisc,
    input  logic        hash_unicast,
    output logic        verdict_valid,
    output logic        verdict_accept
);
    import dafl_pkg::*;

    localparam int ADDR_W = BYTE_W * ADDR_BYTES;
    localparam int CNT_W  = $clog2(ADDR_BYTES + 1);
    localparam int TBL_N  = 1 << HASH_BITS;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);

    dafl_state_e state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic                 take;
    logic                 take_last;
    logic                 decision_q;
    logic                 rule_accept;
    logic [HASH_BITS-1:0] idx_nxt;
    logic [ADDR_W-1:0]    addr_nxt;
    logic [ADDR_W-1:0]    station;
    logic [TBL_N-1:0]     table_bits;

    assign station    = {station_hi, station_lo};
    assign table_bits = {hash_high, hash_low};
    assign take       = byte_valid && !frame_start && (state_q == ST_GATHER);
    assign take_last  = take && (cnt_q == LAST_CNT);

    dafl_crc #(.BYTE_W(BYTE_W), .HASH_BITS(HASH_BITS)) i_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (frame_start),
        .take    (take),
        .din     (byte_data),
        .idx_nxt (idx_nxt)
    );

    dafl_addr_reg #(.BYTE_W(BYTE_W), .ADDR_BYTES(ADDR_BYTES)) i_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (frame_start),
        .take     (take),
        .din      (byte_data),
        .addr_nxt (addr_nxt)
    );

    dafl_rules #(.BYTE_W(BYTE_W), .ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) i_rules (
        .addr         (addr_nxt),
        .idx          (idx_nxt),
        .station      (station),
        .table_bits   (table_bits),
        .reject_bcast (reject_bcast),
        .promisc      (promisc),
        .hash_unicast (hash_unicast),
        .accept       (rule_accept)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (frame_start) state_d = ST_GATHER;
            ST_GATHER: begin
                if (frame_start)    state_d = ST_GATHER;
                else if (take_last) state_d = ST_HOLD;
            end
            ST_HOLD:   if (frame_start) state_d = ST_GATHER;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register, byte count and frozen decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            decision_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (frame_start) begin
                cnt_q      <= '0;
                decision_q <= 1'b0;
            end else if (take) begin
                cnt_q <= cnt_q + 1'b1;
                if (take_last) decision_q <= rule_accept;
            end
        end
    end

    // Outputs
    always_comb begin
        verdict_valid  = (state_q == ST_HOLD);
        verdict_accept = (state_q == ST_HOLD) && decision_q;
    end

    assert_valid_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !frame_start && state_q == ST_GATHER && cnt_q == LAST_CNT) |=> verdict_valid);

    assert_verdict_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && !frame_start) |=> (verdict_valid && $stable(verdict_accept)));

    assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !verdict_valid);

    assert_promisc_accepts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_last && promisc) |=> verdict_accept);

    assert_bcast_rejected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_last && (&addr_nxt) && reject_bcast && !promisc) |=> !verdict_accept);

    assert_accept_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !verdict_valid |-> !verdict_accept);

    assert_count_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(ADDR_BYTES));

endmodule

// File: tb/test_dst_addr_filter.sv
module test_dst_addr_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [31:0] station_lo = 32'h0;
    logic [15:0] station_hi = 16'h0;
    logic [31:0] hash_low = 32'h0;
    logic [31:0] hash_high = 32'h0;
    logic        reject_bcast = 1'b0;
    logic        promisc = 1'b0;
    logic        hash_unicast = 1'b0;
    logic        verdict_valid;
    logic        verdict_accept;

    int checks = 0;
    int fails  = 0;
    bit exp_q[$];
    string tag_q[$];
    bit last_exp;
    logic prev_valid = 1'b0;

    always #5 clk = ~clk;

    dst_addr_filter i_dst_addr_filter (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .station_lo(station_lo), .station_hi(station_hi),
        .hash_low(hash_low), .hash_high(hash_high),
        .reject_bcast(reject_bcast), .promisc(promisc),
        .hash_unicast(hash_unicast),
        .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    function automatic logic [5:0] model_idx(input logic [47:0] a);
        logic [31:0] c;
        logic fb;
        c = 32'hFFFFFFFF;
        for (int b = 5; b >= 0; b--) begin
            for (int i = 0; i < 8; i++) begin
                fb = c[31] ^ a[b*8+i];
                c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
            end
        end
        return c[31:26];
    endfunction

    function automatic bit model_accept(input logic [47:0] a);
        logic [5:0] ix;
        bit hit;
        ix  = model_idx(a);
        hit = ix[5] ? hash_high[ix[4:0]] : hash_low[ix[4:0]];
        if (promisc) return 1'b1;
        if (a == 48'hFFFFFFFFFFFF) return !reject_bcast;
        if (a[40]) return hit;
        return (a == {station_hi, station_lo}) || (hash_unicast && hit);
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (verdict_valid && !prev_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R7 actual=unexpected verdict expected=none");
                end else begin
                    check(tag_q.pop_front(), verdict_accept, exp_q.pop_front());
                end
            end
            prev_valid <= verdict_valid;
        end
    end

    task automatic send_frame(input logic [47:0] a, input string req,
                              input int gap, input bit junk);
        last_exp = model_accept(a);
        exp_q.push_back(last_exp);
        tag_q.push_back(req);
        @(negedge clk);
        frame_start = 1'b1; byte_valid = junk; byte_data = 8'hA5;
        @(negedge clk);
        frame_start = 1'b0; byte_valid = 1'b0;
        check("R8", verdict_valid, 1'b0);
        for (int b = 5; b >= 0; b--) begin
            byte_valid = 1'b1; byte_data = a[b*8 +: 8];
            @(negedge clk);
            byte_valid = 1'b0;
            if (b != 0) begin
                check("R7", verdict_valid, 1'b0);
                for (int g = 0; g < gap; g++) @(negedge clk);
            end
        end
        check("R7", verdict_valid, 1'b1);
    endtask

    function automatic logic [47:0] find_mcast(input bit high);
        logic [47:0] a;
        for (int k = 0; k < 256; k++) begin
            a = {8'h01, 8'h00, 8'h5E, 8'h10, 8'h20, 8'(k)};
            if (model_idx(a)[5] == high) return a;
        end
        return 48'h0100_5E10_2000;
    endfunction

    task automatic set_bit(input logic [5:0] ix);
        hash_low = 32'h0; hash_high = 32'h0;
        if (ix[5]) hash_high[ix[4:0]] = 1'b1;
        else       hash_low[ix[4:0]] = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [47:0] ml, mh, uc;
        repeat (3) @(negedge clk);
        check("R1", verdict_valid, 1'b0);
        check("R1", verdict_accept, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", verdict_accept, 1'b0);

        station_hi = 16'h0211; station_lo = 32'h22334455;
        send_frame(48'h021122334455, "R5", 0, 1'b0);
        send_frame(48'h021122334456, "R6", 0, 1'b0);
        send_frame(48'h041122334455, "R5", 1, 1'b0);

        uc = 48'h0A0B0C0D0E0F;
        set_bit(model_idx(uc));
        send_frame(uc, "R6", 0, 1'b0);
        hash_unicast = 1'b1;
        send_frame(uc, "R6", 0, 1'b0);
        set_bit(~model_idx(uc));
        send_frame(uc, "R6", 0, 1'b0);
        hash_unicast = 1'b0;

        ml = find_mcast(1'b0);
        mh = find_mcast(1'b1);
        set_bit(model_idx(ml));
        send_frame(ml, "R2", 0, 1'b0);
        send_frame(mh, "R2", 2, 1'b0);
        set_bit(model_idx(mh));
        send_frame(mh, "R2", 0, 1'b0);
        send_frame(ml, "R2", 0, 1'b0);

        hash_low = '1; hash_high = '1;
        reject_bcast = 1'b1;
        send_frame(48'hFFFFFFFFFFFF, "R3", 0, 1'b0);
        reject_bcast = 1'b0;
        hash_low = '0; hash_high = '0;
        send_frame(48'hFFFFFFFFFFFF, "R3", 0, 1'b0);

        promisc = 1'b1; reject_bcast = 1'b1;
        send_frame(48'hFFFFFFFFFFFF, "R4", 0, 1'b0);
        send_frame(48'h123456789ABC, "R4", 0, 1'b0);
        promisc = 1'b0; reject_bcast = 1'b0;

        // Byte in the frame-start cycle must be ignored (R8)
        send_frame(48'h021122334455, "R8", 1, 1'b1);

        // Extra bytes and input changes after the verdict (R7, R9)
        byte_valid = 1'b1; byte_data = 8'hEE;
        repeat (3) @(negedge clk);
        byte_valid = 1'b0;
        check("R7", verdict_valid, 1'b1);
        check("R7", verdict_accept, last_exp);
        station_lo = 32'h0; promisc = 1'b0; hash_unicast = 1'b1;
        @(negedge clk);
        check("R9", verdict_accept, last_exp);
        send_frame(48'h060000000001, "R9", 0, 1'b0);
        promisc = 1'b1; station_lo = 32'h00000001; station_hi = 16'h0600;
        @(negedge clk);
        check("R9", verdict_accept, last_exp);
        promisc = 1'b0; hash_unicast = 1'b0;

        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        check("R8", verdict_valid, 1'b0);
        check("R10", verdict_accept, 1'b0);

        repeat (2) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R7 actual=%0d pending expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule